// File: doc/BRIEF.md
# Dual-Lane Instruction Pair Dispatcher

This block sits between instruction fetch and a two-lane execute stage. Each fetch word is 32 bits, aligned, and holds either two 16-bit short instructions or one 32-bit long instruction. The two lanes are not alike. The resource lane executes IO-resource and arithmetic shorts. The memory lane executes memory-access, branch and arithmetic shorts. A long instruction occupies both lanes in the same cycle.

The dispatcher reads a class field in the top bits of each halfword. It places each short in a lane that may legally take it, with arithmetic filling whichever lane the other halfword leaves free. When both halfwords need the same lane, it splits the word across two cycles and pads the idle lane with a no-op. Fetch words arrive on a valid/ready handshake. Each lane has its own ready input, and the block advances only in a cycle when both lanes are ready.

Top module: `lane_pair_dispatch`

## Requirements
- R1: The class of a halfword is taken from bits [15:13]. The codes are 000 arithmetic, 001 memory, 010 branch and 011 IO resource. Code 111 in the lower halfword marks a long instruction. Every other code, including 111 in the upper halfword, counts as arithmetic.
- R2: For a long instruction, both lane-valids go high together with `pair_long`. `res_instr` carries the lower halfword and `mem_instr` carries the upper halfword.
- R3: A short in the resource lane is never memory or branch class. A short in the memory lane is never IO class.
- R4: An arithmetic short goes to the lane that the other halfword does not require. When both halfwords are arithmetic, the lower one goes to the resource lane and the upper one to the memory lane.
- R5: If both halfwords require the same lane, the lower halfword issues first with a no-op partner. The upper halfword issues on the next advance, also with a no-op partner. `fetch_ready` stays low between the two issues.
- R6: A lane whose valid is low drives `0x0000` on its instruction bus.
- R7: When `res_ready` and `mem_ready` are not both high, all outputs hold their values and `fetch_ready` is low.
- R8: Reset clears both lane-valids, `pair_long` and any pending upper halfword. The pending halfword is never issued after reset.
- R9: If an advance happens with no fetch word offered and nothing pending, both lanes become invalid.
- R10: `fetch_ready` is high exactly when both lanes are ready and no upper halfword is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Fetch word offered |
| fetch_word | input | 32 | Aligned fetch word, lower halfword in [15:0] |
| fetch_ready | output | 1 | Fetch word accepted this cycle |
| res_ready | input | 1 | Resource lane can take a new slot |
| mem_ready | input | 1 | Memory lane can take a new slot |
| res_valid | output | 1 | Resource lane slot holds an instruction |
| res_instr | output | 16 | Resource lane instruction halfword |
| mem_valid | output | 1 | Memory lane slot holds an instruction |
| mem_instr | output | 16 | Memory lane instruction halfword |
| pair_long | output | 1 | Both lanes carry one long instruction |

## Verification
A corrupted pending-halfword register shows one cycle after the split word is taken. The second issue then carries the wrong halfword or lane, or it is missing, and `fetch_ready` rises or stays low at the wrong time. A wrong lane choice in the steering shows on the very next advance, as a halfword on the wrong bus or a class that is illegal for its lane. A faulty advance enable shows as outputs changing while a lane is stalled. The bench checks both cycles of every split and samples the outputs one edge after each stimulus.

// File: rtl/lpd_pkg.sv
package lpd_pkg;
  localparam int HALF_W = 16;
  localparam int CLS_W  = 3;

  localparam logic [CLS_W-1:0] CLS_ARITH  = 3'b000;
  localparam logic [CLS_W-1:0] CLS_MEM    = 3'b001;
  localparam logic [CLS_W-1:0] CLS_BRANCH = 3'b010;
  localparam logic [CLS_W-1:0] CLS_IO     = 3'b011;
  localparam logic [CLS_W-1:0] CLS_PREFIX = 3'b111;

  typedef enum logic [1:0] {
    NEED_ANY  = 2'd0,
    NEED_RES  = 2'd1,
    NEED_MEM  = 2'd2,
    NEED_PAIR = 2'd3
  } lane_need_e;

  typedef struct packed {
    logic              rv;
    logic [HALF_W-1:0] ri;
    logic              mv;
    logic [HALF_W-1:0] mi;
    logic              lng;
  } issue_t;

  function automatic issue_t idle_issue();
    issue_t t;
    t.rv  = 1'b0;
    t.ri  = '0;
    t.mv  = 1'b0;
    t.mi  = '0;
    t.lng = 1'b0;
    return t;
  endfunction

  function automatic issue_t single_issue(logic [HALF_W-1:0] hw, lane_need_e need);
    issue_t t;
    t = idle_issue();
    if (need == NEED_MEM) begin
      t.mv = 1'b1;
      t.mi = hw;
    end else begin
      t.rv = 1'b1;
      t.ri = hw;
    end
    return t;
  endfunction
endpackage

// File: rtl/lpd_hw_class.sv
module lpd_hw_class
  import lpd_pkg::*;
#(
  parameter int  HW_W      = HALF_W,
  parameter int  CW        = CLS_W,
  parameter bit  IS_LOWER  = 1'b1
) (
  input  logic [HW_W-1:0] hw,
  output lane_need_e      need
);
  logic [CW-1:0] cls;

  assign cls = hw[HW_W-1 -: CW];

  always_comb begin
    unique case (cls)
      CLS_MEM, CLS_BRANCH: need = NEED_MEM;
      CLS_IO:              need = NEED_RES;
      CLS_PREFIX:          need = IS_LOWER ? NEED_PAIR : NEED_ANY;
      default:             need = NEED_ANY;
    endcase
  end
endmodule

// File: rtl/lpd_steer.sv
module lpd_steer
  import lpd_pkg::*;
(
  input  logic [HALF_W-1:0] lo_hw,
  input  logic [HALF_W-1:0] hi_hw,
  input  lane_need_e        lo_need,
  input  lane_need_e        hi_need,
  output issue_t            first,
  output logic              split
);
  logic conflict;
  logic lo_to_mem;

  assign conflict  = (lo_need == hi_need) &&
                     ((lo_need == NEED_RES) || (lo_need == NEED_MEM));
  assign lo_to_mem = (lo_need == NEED_MEM) || (hi_need == NEED_RES);

  always_comb begin
    first = idle_issue();
    split = 1'b0;
    if (lo_need == NEED_PAIR) begin
      first.rv  = 1'b1;
      first.ri  = lo_hw;
      first.mv  = 1'b1;
      first.mi  = hi_hw;
      first.lng = 1'b1;
    end else if (conflict) begin
      first = single_issue(lo_hw, lo_need);
      split = 1'b1;
    end else begin
      first.rv = 1'b1;
      first.mv = 1'b1;
      if (lo_to_mem) begin
        first.ri = hi_hw;
        first.mi = lo_hw;
      end else begin
        first.ri = lo_hw;
        first.mi = hi_hw;
      end
    end
  end
endmodule

// File: rtl/lpd_issue_reg.sv
module lpd_issue_reg
  import lpd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  issue_t d,
  output issue_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= idle_issue();
    end else if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/lane_pair_dispatch.sv
module lane_pair_dispatch
  import lpd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [2*HALF_W-1:0] fetch_word,
  output logic              fetch_ready,
  input  logic              res_ready,
  input  logic              mem_ready,
  output logic              res_valid,
  output logic [HALF_W-1:0] res_instr,
  output logic              mem_valid,
  output logic [HALF_W-1:0] mem_instr,
  output logic              pair_long
);
  localparam int NUM_HW = 2;

  logic [HALF_W-1:0] hw_a   [NUM_HW];
  lane_need_e        need_a [NUM_HW];

  for (genvar g = 0; g < NUM_HW; g++) begin : g_dec
    assign hw_a[g] = fetch_word[g*HALF_W +: HALF_W];
    lpd_hw_class #(
      .HW_W     (HALF_W),
      .CW       (CLS_W),
      .IS_LOWER (g == 0)
    ) dec_i (
      .hw   (hw_a[g]),
      .need (need_a[g])
    );
  end

  issue_t steer_first;
  logic   steer_split;

  lpd_steer steer_i (
    .lo_hw   (hw_a[0]),
    .hi_hw   (hw_a[1]),
    .lo_need (need_a[0]),
    .hi_need (need_a[1]),
    .first   (steer_first),
    .split   (steer_split)
  );

  logic              advance;
  logic              take;
  logic              pend_valid_q, pend_valid_d;
  logic [HALF_W-1:0] pend_hw_q, pend_hw_d;
  lane_need_e        pend_need_q, pend_need_d;
  issue_t            issue_d, issue_q;

  assign advance     = res_ready & mem_ready;
  assign fetch_ready = advance & ~pend_valid_q;
  assign take        = fetch_ready & fetch_valid;

  always_comb begin
    pend_valid_d = pend_valid_q;
    pend_hw_d    = pend_hw_q;
    pend_need_d  = pend_need_q;
    if (pend_valid_q) begin
      issue_d = single_issue(pend_hw_q, pend_need_q);
    end else if (take) begin
      issue_d = steer_first;
    end else begin
      issue_d = idle_issue();
    end
    if (advance) begin
      pend_valid_d = take & steer_split;
      pend_hw_d    = hw_a[1];
      pend_need_d  = need_a[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid_q <= 1'b0;
    end else if (advance) begin
      pend_valid_q <= pend_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      pend_hw_q   <= pend_hw_d;
      pend_need_q <= pend_need_d;
    end
  end

  lpd_issue_reg out_reg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (advance),
    .d     (issue_d),
    .q     (issue_q)
  );

  assign res_valid = issue_q.rv;
  assign res_instr = issue_q.ri;
  assign mem_valid = issue_q.mv;
  assign mem_instr = issue_q.mi;
  assign pair_long = issue_q.lng;
endmodule

// File: rtl/lpd_checker.sv
module lpd_checker
  import lpd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_ready,
  input logic              res_ready,
  input logic              mem_ready,
  input logic              res_valid,
  input logic [HALF_W-1:0] res_instr,
  input logic              mem_valid,
  input logic [HALF_W-1:0] mem_instr,
  input logic              pair_long
);
  logic [CLS_W-1:0] res_cls, mem_cls;
  assign res_cls = res_instr[HALF_W-1 -: CLS_W];
  assign mem_cls = mem_instr[HALF_W-1 -: CLS_W];

  assert_res_noop_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_instr == '0));
  assert_mem_noop_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_valid |-> (mem_instr == '0));
  assert_res_lane_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !pair_long) |-> !((res_cls == CLS_MEM) || (res_cls == CLS_BRANCH)));
  assert_mem_lane_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !pair_long) |-> (mem_cls != CLS_IO));
  assert_long_both_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_long |-> (res_valid && mem_valid && (res_cls == CLS_PREFIX)));
  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(res_ready && mem_ready) |=> ($stable(res_instr) && $stable(mem_instr) &&
                                   $stable(res_valid) && $stable(mem_valid) &&
                                   $stable(pair_long)));
  assert_fetch_ready_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> (res_ready && mem_ready));
endmodule

bind lane_pair_dispatch lpd_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_ready (fetch_ready),
  .res_ready   (res_ready),
  .mem_ready   (mem_ready),
  .res_valid   (res_valid),
  .res_instr   (res_instr),
  .mem_valid   (mem_valid),
  .mem_instr   (mem_instr),
  .pair_long   (pair_long)
);

// File: tb/lane_pair_dispatch_tb.sv
`timescale 1ns/1ps
module lane_pair_dispatch_tb_top;
  logic        clk;
  logic        rst_n;
  logic        fetch_valid;
  logic [31:0] fetch_word;
  logic        fetch_ready;
  logic        res_ready, mem_ready;
  logic        res_valid, mem_valid, pair_long;
  logic [15:0] res_instr, mem_instr;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  lane_pair_dispatch dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_word  (fetch_word),
    .fetch_ready (fetch_ready),
    .res_ready   (res_ready),
    .mem_ready   (mem_ready),
    .res_valid   (res_valid),
    .res_instr   (res_instr),
    .mem_valid   (mem_valid),
    .mem_instr   (mem_instr),
    .pair_long   (pair_long)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic [31:0] word;
    logic        rv1;
    logic [15:0] ri1;
    logic        mv1;
    logic [15:0] mi1;
    logic        lng;
    logic        split;
    logic        rv2;
    logic [15:0] ri2;
    logic        mv2;
    logic [15:0] mi2;
  } vec_t;

  // Class codes in bits [15:13]: 0x0xxx arith, 0x2xxx mem, 0x4xxx branch,
  // 0x6xxx IO, 0x8xxx other (arith), 0xExxx long prefix.
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'h0321_0123, 1'b1, 16'h0123, 1'b1, 16'h0321, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0}, // R4 both arith
    '{32'h0123_2456, 1'b1, 16'h0123, 1'b1, 16'h2456, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0}, // R4 mem+arith
    '{32'h6abc_0123, 1'b1, 16'h6abc, 1'b1, 16'h0123, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0}, // R4 arith+IO
    '{32'h2456_6abc, 1'b1, 16'h6abc, 1'b1, 16'h2456, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0}, // R3 IO+mem
    '{32'h6abc_4789, 1'b1, 16'h6abc, 1'b1, 16'h4789, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0}, // R3 branch+IO
    '{32'h1234_e00f, 1'b1, 16'he00f, 1'b1, 16'h1234, 1'b1, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0}, // R2 long
    '{32'h6abc_8111, 1'b1, 16'h6abc, 1'b1, 16'h8111, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0}, // R1 code 100 arith
    '{32'he555_0123, 1'b1, 16'h0123, 1'b1, 16'he555, 1'b0, 1'b0, 1'b0, 16'h0, 1'b0, 16'h0}, // R1 upper 111 arith
    '{32'h6def_6abc, 1'b1, 16'h6abc, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 16'h6def, 1'b0, 16'h0}, // R5 IO+IO
    '{32'h4789_2456, 1'b0, 16'h0000, 1'b1, 16'h2456, 1'b0, 1'b1, 1'b0, 16'h0, 1'b1, 16'h4789}  // R5 mem+branch
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_out(string tag, logic rv, logic [15:0] ri, logic mv,
                           logic [15:0] mi, logic lng);
    check({tag, " res_valid"}, {31'b0, res_valid}, {31'b0, rv});
    check({tag, " res_instr"}, {16'b0, res_instr}, {16'b0, ri});
    check({tag, " mem_valid"}, {31'b0, mem_valid}, {31'b0, mv});
    check({tag, " mem_instr"}, {16'b0, mem_instr}, {16'b0, mi});
    check({tag, " pair_long"}, {31'b0, pair_long}, {31'b0, lng});
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=5000", cycles);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n       = 1'b0;
    fetch_valid = 1'b0;
    fetch_word  = '0;
    res_ready   = 1'b1;
    mem_ready   = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // R8 reset state
    check_out("R8 reset", 1'b0, 16'h0, 1'b0, 16'h0, 1'b0);
    rst_n = 1'b1;
    #1;
    check("R10 ready after reset", {31'b0, fetch_ready}, 32'd1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      fetch_word  = VECS[i].word;
      fetch_valid = 1'b1;
      step();
      check_out($sformatf("R1 vec%0d first", i), VECS[i].rv1, VECS[i].ri1,
                VECS[i].mv1, VECS[i].mi1, VECS[i].lng);
      if (VECS[i].split) begin
        check($sformatf("R5 vec%0d ready low", i), {31'b0, fetch_ready}, 32'd0);
        step();
        check_out($sformatf("R5 vec%0d second", i), VECS[i].rv2, VECS[i].ri2,
                  VECS[i].mv2, VECS[i].mi2, 1'b0);
        check($sformatf("R10 vec%0d ready back", i), {31'b0, fetch_ready}, 32'd1);
      end
    end

    // R9 no fetch offered
    fetch_valid = 1'b0;
    step();
    check_out("R9 idle", 1'b0, 16'h0, 1'b0, 16'h0, 1'b0);

    // R7 stall: load a word, then stall each lane in turn
    fetch_word  = 32'h0321_0123;
    fetch_valid = 1'b1;
    step();
    fetch_word = 32'h1234_e00f;
    res_ready  = 1'b0;
    #1;
    check("R7 fetch_ready low res stall", {31'b0, fetch_ready}, 32'd0);
    step();
    check_out("R7 hold res stall", 1'b1, 16'h0123, 1'b1, 16'h0321, 1'b0);
    res_ready = 1'b1;
    mem_ready = 1'b0;
    #1;
    check("R7 fetch_ready low mem stall", {31'b0, fetch_ready}, 32'd0);
    step();
    check_out("R7 hold mem stall", 1'b1, 16'h0123, 1'b1, 16'h0321, 1'b0);
    mem_ready = 1'b1;
    step();
    check_out("R2 after stall", 1'b1, 16'he00f, 1'b1, 16'h1234, 1'b1);

    // R7 stall during a split: second half waits
    fetch_word = 32'h6def_6abc;
    step();
    fetch_valid = 1'b0;
    mem_ready   = 1'b0;
    step();
    check_out("R7 split hold", 1'b1, 16'h6abc, 1'b0, 16'h0, 1'b0);
    mem_ready = 1'b1;
    step();
    check_out("R5 split after stall", 1'b1, 16'h6def, 1'b0, 16'h0, 1'b0);

    // R8 reset with a pending upper halfword
    fetch_word  = 32'h4789_2456;
    fetch_valid = 1'b1;
    step();
    fetch_valid = 1'b0;
    rst_n       = 1'b0;
    #1;
    check_out("R8 async clear", 1'b0, 16'h0, 1'b0, 16'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 R10 ready no pending", {31'b0, fetch_ready}, 32'd1);
    step();
    check_out("R8 pending dropped", 1'b0, 16'h0, 1'b0, 16'h0, 1'b0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule